// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Unit

This unit keeps the status byte of a 1 MiB serial flash and decides, for every decoded command from the serial front end, whether that command may proceed. It tracks two things. The first is whether a program, erase or status write is still in flight. The second is whether writes are currently enabled. It also turns the four block-protect bits into an explicit protected address window. The array sequencer reports its own busy level and pulses a completion line when a write ends. The write-protect pin gates status writes.

Each command arrives as a single-cycle `cmd_valid` strobe together with an opcode, a 20-bit address and a data byte. The command interface has no back-pressure: the unit takes one command in any cycle and never stalls the front end. Exactly one cycle later it returns a verdict strobe `acc_valid` with `acc_ok`. The status byte and the protect window are plain level outputs, and they reflect the registered state at all times.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status byte is 00h, `acc_valid` is 0, and `prot_none` is 1. The status byte is laid out as bit0 busy, bit1 write-enable, bits 4:2 protect code, bit5 bottom-select, and bits 7:6 zero.
- R2: Opcode 1 (enable) sets the write-enable bit and opcode 2 (disable) clears it. Each returns `acc_ok`=1 in the cycle after its strobe.
- R3: While write-enable is 0, the write opcodes are rejected with `acc_ok`=0 and change no state. The write opcodes are 3 (status write), 4 (4 KiB erase), 5 (64 KiB erase), 6 (chip erase) and 7 (256-byte page program).
- R4: An accepted write opcode sets the busy bit, which stays 1 until a `done_i` pulse. The busy bit is also 1 whenever `seq_busy_i` is high.
- R5: A `done_i` pulse while a write is pending clears both the busy bit and the write-enable bit.
- R6: A rejected write, including one that targets a protected address, leaves write-enable at its earlier value.
- R7: An accepted status write copies `cmd_wdata[5:2]` into status bits 5:2. While `wp_n` is low, status writes are rejected.
- R8: With bottom-select at 0, protect codes 1, 2, 3 and 4 protect F0000h, E0000h, C0000h and 80000h respectively, each up to FFFFFh.
- R9: With bottom-select at 1, protect codes 1, 2, 3 and 4 protect from 00000h up to 0FFFFh, 1FFFFh, 3FFFFh and 7FFFFh respectively.
- R10: Protect code 0 protects nothing (`prot_none`=1). Codes 5, 6 and 7 protect 00000h to FFFFFh whatever the value of bottom-select.
- R11: Chip erase is accepted only when the protect code is 0.
- R12: While busy, every opcode except 0 (status read) is rejected. Opcode 0 is always accepted.
- R13: The erase and program opcodes are checked against the protected window using the base address of the target, which is the address with its low 12, 16 or 8 bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 20 | Target byte address |
| cmd_wdata | input | 8 | Status write data |
| wp_n | input | 1 | Write-protect pin, low blocks status writes |
| seq_busy_i | input | 1 | Array sequencer busy level |
| done_i | input | 1 | Write completion pulse |
| status_o | output | 8 | Status byte |
| acc_valid | output | 1 | Verdict strobe, one cycle after cmd_valid |
| acc_ok | output | 1 | Command accepted |
| prot_lo | output | 20 | Lowest protected address |
| prot_hi | output | 20 | Highest protected address |
| prot_none | output | 1 | No address protected |

## Verification
A command strobed at one rising edge produces its verdict at the next edge. The bench drives on falling edges, queues the expected verdict at the moment it issues the strobe, and has a monitor compare `acc_ok` at the falling edge after `acc_valid` rises. Status and protect-window effects, and the effect of a `done_i` pulse, are registered at the same edge as the verdict. The bench therefore reads `status_o` and the window one full cycle after the stimulus. Only `seq_busy_i` reaches the busy bit combinationally, and the bench samples it half a cycle after driving it.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int ADDR_W = 20;
  localparam int SUB_SHIFT = 12;
  localparam int SEC_SHIFT = 16;
  localparam int PAGE_SHIFT = 8;

  typedef enum logic [2:0] {
    OP_RDSR = 3'd0,
    OP_WREN = 3'd1,
    OP_WRDI = 3'd2,
    OP_WRSR = 3'd3,
    OP_SUBER = 3'd4,
    OP_SECER = 3'd5,
    OP_CHIPER = 3'd6,
    OP_PROG = 3'd7
  } op_e;
endpackage

// File: rtl/prot_window.sv
module prot_window #(
  parameter int AW = 20
) (
  input  logic          bottom,
  input  logic [2:0]    code,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi,
  output logic          none
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};
  logic [AW-1:0] span;
  logic [2:0] sh;

  always_comb begin
    sh = 3'd5 - code;
    span = TOP >> sh;
    none = (code == 3'd0);
    lo = '0;
    hi = TOP;
    if (code >= 3'd1 && code <= 3'd4) begin
      if (bottom) begin
        lo = '0;
        hi = span;
      end else begin
        lo = ~span;
        hi = TOP;
      end
    end
  end

  // R10
  always_comb begin
    window_order_chk: assert (none || lo <= hi);
  end
endmodule

// File: rtl/access_check.sv
module access_check
  import flash_status_pkg::*;
#(
  parameter int AW = 20
) (
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic          busy,
  input  logic          wen,
  input  logic          wp_n,
  input  logic [2:0]    code,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          none,
  output logic          ok
);
  logic [AW-1:0] base;
  logic hit;

  always_comb begin
    case (op)
      OP_SUBER: base = addr & ~((AW)'((1 << SUB_SHIFT) - 1));
      OP_SECER: base = addr & ~((AW)'((1 << SEC_SHIFT) - 1));
      OP_PROG:  base = addr & ~((AW)'((1 << PAGE_SHIFT) - 1));
      default:  base = addr;
    endcase
    hit = !none && base >= lo && base <= hi;
    case (op)
      OP_RDSR:  ok = 1'b1;
      OP_WREN, OP_WRDI: ok = !busy;
      OP_WRSR:  ok = !busy && wen && wp_n;
      OP_CHIPER: ok = !busy && wen && (code == 3'd0);
      default:  ok = !busy && wen && !hit;
    endcase
  end
endmodule

// File: rtl/status_core.sv
module status_core
  import flash_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  op_e        op,
  input  logic [7:0] wdata,
  input  logic       ok,
  input  logic       seq_busy_i,
  input  logic       done_i,
  output logic       busy,
  output logic       wen,
  output logic [2:0] code,
  output logic       bottom,
  output logic       acc_valid,
  output logic       acc_ok
);
  logic pending;

  assign busy = pending | seq_busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      wen <= 1'b0;
      code <= 3'd0;
      bottom <= 1'b0;
      acc_valid <= 1'b0;
      acc_ok <= 1'b0;
    end else begin
      acc_valid <= cmd_valid;
      acc_ok <= cmd_valid & ok;
      if (done_i && pending) begin
        pending <= 1'b0;
        wen <= 1'b0;
      end
      if (cmd_valid && ok) begin
        case (op)
          OP_WREN: wen <= 1'b1;
          OP_WRDI: wen <= 1'b0;
          OP_WRSR: begin
            code <= wdata[4:2];
            bottom <= wdata[5];
            pending <= 1'b1;
          end
          OP_SUBER, OP_SECER, OP_CHIPER, OP_PROG: pending <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R2
  verdict_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> acc_valid);
  // R5
  done_clears_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && pending) |=> (!wen && !pending));
  // R6
  reject_keeps_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ok && !done_i) |=> $stable(wen));
  // R11
  chip_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_CHIPER && code != 3'd0) |=> !acc_ok);
  // R12
  busy_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && op != OP_RDSR) |=> !acc_ok);
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import flash_status_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_wdata,
  input  logic          wp_n,
  input  logic          seq_busy_i,
  input  logic          done_i,
  output logic [7:0]    status_o,
  output logic          acc_valid,
  output logic          acc_ok,
  output logic [AW-1:0] prot_lo,
  output logic [AW-1:0] prot_hi,
  output logic          prot_none
);
  op_e op;
  logic busy, wen, bottom, ok;
  logic [2:0] code;

  assign op = op_e'(cmd_op);
  assign status_o = {2'b00, bottom, code, wen, busy};

  prot_window #(.AW(AW)) u_win (
    .bottom(bottom), .code(code), .lo(prot_lo), .hi(prot_hi), .none(prot_none)
  );

  access_check #(.AW(AW)) u_chk (
    .op(op), .addr(cmd_addr), .busy(busy), .wen(wen), .wp_n(wp_n),
    .code(code), .lo(prot_lo), .hi(prot_hi), .none(prot_none), .ok(ok)
  );

  status_core u_core (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op), .wdata(cmd_wdata),
    .ok(ok), .seq_busy_i(seq_busy_i), .done_i(done_i), .busy(busy), .wen(wen),
    .code(code), .bottom(bottom), .acc_valid(acc_valid), .acc_ok(acc_ok)
  );
endmodule

// File: tb/sim_flash_status_unit.sv
module sim_flash_status_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [19:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic wp_n = 1'b1;
  logic seq_busy_i = 1'b0;
  logic done_i = 1'b0;
  logic [7:0] status_o;
  logic acc_valid, acc_ok;
  logic [19:0] prot_lo, prot_hi;
  logic prot_none;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .seq_busy_i(seq_busy_i), .done_i(done_i), .status_o(status_o),
    .acc_valid(acc_valid), .acc_ok(acc_ok), .prot_lo(prot_lo),
    .prot_hi(prot_hi), .prot_none(prot_none)
  );

  // monitor: pop expected verdicts as the design produces them
  always @(negedge clk) begin
    #1;
    if (rst_n && acc_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL verdict without command: got %0d expected none", acc_ok);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (acc_ok !== e) begin
          errors++;
          $display("FAIL %s verdict: got %0d expected %0d", t, acc_ok, e);
        end
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [19:0] a,
                       input logic [7:0] d, input bit exp_ok, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    exp_q.push_back(exp_ok);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_write();
    @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  task automatic chk_status(input logic [7:0] e, input string tag);
    #2;
    checks++;
    if (status_o !== e) begin
      errors++;
      $display("FAIL %s status: got %02h expected %02h", tag, status_o, e);
    end
  endtask

  task automatic chk_win(input logic [19:0] lo, input logic [19:0] hi,
                         input logic none, input string tag);
    #2;
    checks++;
    if (prot_none !== none || (!none && (prot_lo !== lo || prot_hi !== hi))) begin
      errors++;
      $display("FAIL %s window: got %05h..%05h none=%0d expected %05h..%05h none=%0d",
               tag, prot_lo, prot_hi, prot_none, lo, hi, none);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_status(8'h00, "R1");
    chk_win(20'h0, 20'h0, 1'b1, "R1");
    checks++;
    if (acc_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 acc_valid: got %0d expected 0", acc_valid);
    end
    // R3 write with enable clear
    issue(3'd7, 20'h00000, 8'h00, 1'b0, "R3");
    chk_status(8'h00, "R3");
    // R2 enable / disable
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    chk_status(8'h02, "R2");
    issue(3'd2, 20'h0, 8'h00, 1'b1, "R2");
    chk_status(8'h00, "R2");
    // R7 status write, R4 busy, R8 top window
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd3, 20'h0, 8'h04, 1'b1, "R7");
    chk_status(8'h07, "R4");
    chk_win(20'hF0000, 20'hFFFFF, 1'b0, "R8");
    // R12 busy rejects all but status read
    issue(3'd1, 20'h0, 8'h00, 1'b0, "R12");
    issue(3'd0, 20'h0, 8'h00, 1'b1, "R12");
    // R5 completion
    finish_write();
    chk_status(8'h04, "R5");
    // R6 / R13 protected page keeps enable
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd7, 20'hF0010, 8'h00, 1'b0, "R13");
    chk_status(8'h06, "R6");
    // R13 64K erase aligned base E0000 outside window
    issue(3'd5, 20'hEFFFF, 8'h00, 1'b1, "R13");
    chk_status(8'h07, "R4");
    finish_write();
    chk_status(8'h04, "R5");
    // R11 chip erase rejected with nonzero code
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd6, 20'h0, 8'h00, 1'b0, "R11");
    chk_status(8'h06, "R6");
    // R9 bottom window
    issue(3'd3, 20'h0, 8'h24, 1'b1, "R7");
    chk_status(8'h27, "R7");
    chk_win(20'h00000, 20'h0FFFF, 1'b0, "R9");
    finish_write();
    chk_status(8'h24, "R5");
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd4, 20'h0FFFF, 8'h00, 1'b0, "R13");
    issue(3'd4, 20'h10000, 8'h00, 1'b1, "R13");
    finish_write();
    // R8 code 4 top half
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd3, 20'h0, 8'h10, 1'b1, "R7");
    chk_status(8'h13, "R7");
    chk_win(20'h80000, 20'hFFFFF, 1'b0, "R8");
    finish_write();
    // R9 code 3 bottom quarter
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd3, 20'h0, 8'h2C, 1'b1, "R7");
    chk_win(20'h00000, 20'h3FFFF, 1'b0, "R9");
    finish_write();
    // R10 code 6 whole array with bottom select clear
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd3, 20'h0, 8'h18, 1'b1, "R7");
    chk_win(20'h00000, 20'hFFFFF, 1'b0, "R10");
    finish_write();
    chk_status(8'h18, "R5");
    // R7 write-protect pin
    wp_n = 1'b0;
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd3, 20'h0, 8'h00, 1'b0, "R7");
    chk_status(8'h1A, "R7");
    wp_n = 1'b1;
    issue(3'd3, 20'h0, 8'h00, 1'b1, "R7");
    chk_status(8'h03, "R7");
    chk_win(20'h0, 20'h0, 1'b1, "R10");
    finish_write();
    chk_status(8'h00, "R5");
    // R11 chip erase accepted at code 0
    issue(3'd1, 20'h0, 8'h00, 1'b1, "R2");
    issue(3'd6, 20'h0, 8'h00, 1'b1, "R11");
    finish_write();
    chk_status(8'h00, "R5");
    // R4 sequencer busy level, R12
    @(negedge clk);
    seq_busy_i = 1'b1;
    chk_status(8'h01, "R4");
    issue(3'd0, 20'h0, 8'h00, 1'b1, "R12");
    issue(3'd1, 20'h0, 8'h00, 1'b0, "R12");
    seq_busy_i = 1'b0;
    chk_status(8'h00, "R12");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 verdicts missing: got %0d pending expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule